// File: doc/BRIEF.md
# Two-Level Address Region Mapper

This block resolves a CPU address into a routing descriptor. The address is cut into 64 KB chunks and 256-byte regions. The chunk number (address bits [23:16]) indexes a first-level table. Each entry of that table holds a valid flag and a pointer to one of several second-level tables. The region number (address bits [15:8]) then indexes the selected second-level table. That entry names where the region is serviced: the external CPU bus, on-chip SRAM, external SDRAM, or a fault response. It also gives a base that replaces the upper address bits. Each 256-byte region can therefore be routed on its own, and a table of region hints can place hot ROM regions in fast memory and the rest in slow memory.

Requests use a valid/ready handshake. Responses come back after a fixed two-stage pipeline and are held while the consumer stalls. Both table levels are filled through a simple write port. A write never changes the result of a lookup that was already accepted when the write arrived. When wide mode is selected, a 32-bit address is folded into the same 24-bit structure.

Top module: `addr_region_mapper`

## Requirements
- R1: After a synchronous reset, resp_valid is 0 and req_ready is 1.
- R2: The first-level entry at index req_addr[23:16] has a valid flag in bit PTR_W and a table pointer in bits [PTR_W-1:0]. When that entry is valid, the descriptor is read from the pointed table at index req_addr[15:8].
- R3: A descriptor holds a 2-bit target in bits [DESC_W-1:DESC_W-2] (00 bus, 01 SRAM, 10 SDRAM, 11 fault) and a base in bits [BASE_W-1:0]. The response target equals the descriptor target, and resp_offset = {base, req_addr[7:0]}. This holds for all four target codes, including 11.
- R4: A lookup whose first-level entry is invalid returns target 11 with resp_offset 0.
- R5: With wide_mode=1, req_addr[31:24] is ignored. With wide_mode=0, a nonzero req_addr[31:24] gives target 11 with resp_offset 0.
- R6: A request accepted at clock edge k appears on the outputs right after edge k+1 when resp_ready is high. Back-to-back requests give one response per cycle.
- R7: While resp_valid=1 and resp_ready=0, the response outputs stay stable and req_ready is 0.
- R8: A table write at cfg_we with cfg_level=0 goes to first-level entry cfg_index. A write with cfg_level=1 goes to entry cfg_index of table cfg_table. A write presented at or after the edge that accepts a request does not affect that request's response. Requests accepted at later edges see the write.
- R9: Adjacent 256-byte regions within one chunk resolve independently. Different chunks may point to different tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1: ignore address bits [31:24] |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 32 | Address to translate |
| resp_valid | output | 1 | Descriptor present |
| resp_ready | input | 1 | Consumer takes descriptor |
| resp_target | output | 2 | 00 bus, 01 SRAM, 10 SDRAM, 11 fault |
| resp_offset | output | BASE_W+8 | Translated offset |
| cfg_we | input | 1 | Table write strobe |
| cfg_level | input | 1 | 0 first level, 1 second level |
| cfg_table | input | PTR_W | Second-level table number |
| cfg_index | input | 8 | Entry index |
| cfg_data | input | BASE_W+2 | Entry contents |

## Verification
The bench targets the write-versus-lookup race. A write is issued in the same cycle as an accepted request, and again one cycle later, to the entry that request is reading. A design that reads the second level late would return the new descriptor instead of the old one. The stall case checks that the output holds still while resp_ready is low. A pipeline that drops or overwrites the held response would show the second request early. The bench also uses an invalid chunk, a nonzero upper byte in narrow mode, and adjacent regions that share one table. A mapper that ignored the valid flag, failed to fold wide addresses, or indexed with the wrong byte would return the wrong target or offset.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  typedef enum logic [1:0] {
    TGT_BUS   = 2'b00,
    TGT_SRAM  = 2'b01,
    TGT_SDRAM = 2'b10,
    TGT_FAULT = 2'b11
  } tgt_e;
endpackage

// File: rtl/map_sram.sv
// Simple dual-port table, synchronous read-first, inferable as block RAM.
module map_sram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/map_resolve.sv
// Second stage: pick the pointed descriptor and register the response.
module map_resolve
  import addr_map_pkg::*;
#(
  parameter int NUM_TABLES = 4,
  parameter int BASE_W = 16,
  localparam int PTR_W  = $clog2(NUM_TABLES),
  localparam int DESC_W = BASE_W + 2,
  localparam int OFF_W  = BASE_W + 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              advance,
  input  logic                              s1_valid,
  input  logic [7:0]                        s1_low,
  input  logic                              s1_upper_bad,
  input  logic [PTR_W:0]                    l1_q,
  input  logic [NUM_TABLES-1:0][DESC_W-1:0] l2_q,
  output logic                              resp_valid,
  output logic [1:0]                        resp_target,
  output logic [OFF_W-1:0]                  resp_offset,
  input  logic                              resp_ready
);
  logic [DESC_W-1:0] sel;
  logic              fault_early;

  always_comb begin
    sel         = l2_q[l1_q[PTR_W-1:0]];
    fault_early = s1_upper_bad || !l1_q[PTR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
    end else if (advance) begin
      resp_valid <= s1_valid;
    end
    if (advance) begin
      if (fault_early) begin
        resp_target <= TGT_FAULT;
        resp_offset <= '0;
      end else begin
        resp_target <= sel[DESC_W-1 -: 2];
        resp_offset <= {sel[BASE_W-1:0], s1_low};
      end
    end
  end

  // R7: a stalled response does not move
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_target) && $stable(resp_offset)));

  // R4: an invalid first-level entry yields a zero-offset fault
  a_r4_invalid_fault: assert property (@(posedge clk) disable iff (rst)
    (advance && s1_valid && !l1_q[PTR_W]) |=>
      (resp_target == 2'b11 && resp_offset == '0));
endmodule

// File: rtl/addr_region_mapper.sv
module addr_region_mapper
  import addr_map_pkg::*;
#(
  parameter int NUM_TABLES = 4,
  parameter int BASE_W = 16,
  localparam int PTR_W  = $clog2(NUM_TABLES),
  localparam int L1_W   = PTR_W + 1,
  localparam int DESC_W = BASE_W + 2,
  localparam int OFF_W  = BASE_W + 8,
  localparam int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [1:0]        resp_target,
  output logic [OFF_W-1:0]  resp_offset,
  input  logic              cfg_we,
  input  logic              cfg_level,
  input  logic [PTR_W-1:0]  cfg_table,
  input  logic [7:0]        cfg_index,
  input  logic [DESC_W-1:0] cfg_data
);
  logic                              advance;
  logic [L1_W-1:0]                   l1_q;
  logic [NUM_TABLES-1:0][DESC_W-1:0] l2_q;
  logic                              s1_valid;
  logic [7:0]                        s1_low;
  logic                              s1_upper_bad;

  always_comb begin
    advance   = !resp_valid || resp_ready;
    req_ready = advance;
  end

  // Level one: chunk index -> {valid, pointer}
  map_sram #(.DEPTH(ENTRIES), .WIDTH(L1_W)) u_l1 (
    .clk     (clk),
    .wr_en   (cfg_we && !cfg_level),
    .wr_addr (cfg_index),
    .wr_data (cfg_data[L1_W-1:0]),
    .rd_en   (advance),
    .rd_addr (req_addr[23:16]),
    .rd_data (l1_q)
  );

  // Level two: every table read in parallel at the same edge as level one
  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_l2
    map_sram #(.DEPTH(ENTRIES), .WIDTH(DESC_W)) u_l2 (
      .clk     (clk),
      .wr_en   (cfg_we && cfg_level && (cfg_table == PTR_W'(t))),
      .wr_addr (cfg_index),
      .wr_data (cfg_data),
      .rd_en   (advance),
      .rd_addr (req_addr[15:8]),
      .rd_data (l2_q[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= req_valid;
    end
    if (advance) begin
      s1_low       <= req_addr[7:0];
      s1_upper_bad <= !wide_mode && (req_addr[31:24] != 8'h00);
    end
  end

  map_resolve #(.NUM_TABLES(NUM_TABLES), .BASE_W(BASE_W)) u_res (
    .clk          (clk),
    .rst          (rst),
    .advance      (advance),
    .s1_valid     (s1_valid),
    .s1_low       (s1_low),
    .s1_upper_bad (s1_upper_bad),
    .l1_q         (l1_q),
    .l2_q         (l2_q),
    .resp_valid   (resp_valid),
    .resp_target  (resp_target),
    .resp_offset  (resp_offset),
    .resp_ready   (resp_ready)
  );

  // R6: accepted request shows up one edge later when not stalled
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) ##1 req_ready |=> resp_valid);

  // R5: narrow mode with a nonzero upper byte faults with zero offset
  a_r5_upper_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !wide_mode && (req_addr[31:24] != 8'h00))
      ##1 req_ready |=> (resp_target == 2'b11 && resp_offset == '0));

  // R7: no new request accepted while a response is stalled
  a_r7_no_accept: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |-> !req_ready);

  // R1/R6: a response only starts from a request that was in stage one
  a_r1_no_phantom: assert property (@(posedge clk) disable iff (rst)
    $rose(resp_valid) |-> $past(s1_valid));
endmodule

// File: tb/sim_addr_region_mapper.sv
module sim_addr_region_mapper;
  localparam int NT = 4;
  localparam int BW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [1:0]  resp_target;
  logic [23:0] resp_offset;
  logic        cfg_we = 1'b0;
  logic        cfg_level = 1'b0;
  logic [1:0]  cfg_table = '0;
  logic [7:0]  cfg_index = '0;
  logic [17:0] cfg_data = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  addr_region_mapper #(.NUM_TABLES(NT), .BASE_W(BW)) u0 (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_target(resp_target), .resp_offset(resp_offset),
    .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_table(cfg_table),
    .cfg_index(cfg_index), .cfg_data(cfg_data)
  );

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
        finish_run();
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare a full response (valid, target, offset)
  task automatic check_resp(string tag, logic [1:0] t, logic [23:0] off);
    check(tag, {5'd0, resp_valid, resp_target, resp_offset}, {5'd0, 1'b1, t, off});
  endtask

  task automatic write_l1(logic [7:0] idx, logic v, logic [1:0] ptr);
    @(negedge clk);
    cfg_we = 1; cfg_level = 0; cfg_index = idx; cfg_data = {15'd0, v, ptr};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic write_l2(logic [1:0] tb, logic [7:0] idx, logic [1:0] t, logic [15:0] base);
    @(negedge clk);
    cfg_we = 1; cfg_level = 1; cfg_table = tb; cfg_index = idx; cfg_data = {t, base};
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Single lookup with resp_ready high; sample after the second edge
  task automatic lookup(logic [31:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_setup();
    for (int i = 0; i < 256; i++) write_l1(i[7:0], 1'b0, 2'd0);
    write_l1(8'h12, 1'b1, 2'd2);
    write_l1(8'h20, 1'b1, 2'd1);
    write_l2(2'd2, 8'h34, 2'b01, 16'hABCD);
    write_l2(2'd2, 8'h35, 2'b10, 16'h0101);
    write_l2(2'd2, 8'h36, 2'b00, 16'h7E00);
    write_l2(2'd2, 8'h37, 2'b11, 16'h00FF);
    write_l2(2'd1, 8'h34, 2'b00, 16'h5A5A);
  endtask

  task automatic t_basic();
    lookup(32'h00123456); check_resp("R2 R3 sram", 2'b01, 24'hABCD56);
    lookup(32'h001235FF); check_resp("R3 R9 sdram adjacent", 2'b10, 24'h0101FF);
    lookup(32'h00123600); check_resp("R3 R9 bus", 2'b00, 24'h7E0000);
    lookup(32'h00123710); check_resp("R3 fault code", 2'b11, 24'h00FF10);
    lookup(32'h00203481); check_resp("R2 R9 other table", 2'b00, 24'h5A5A81);
  endtask

  task automatic t_invalid();
    lookup(32'h00553456); check_resp("R4 invalid chunk", 2'b11, 24'h000000);
  endtask

  task automatic t_wide();
    wide_mode = 1;
    lookup(32'hFF123456); check_resp("R5 wide ignores top", 2'b01, 24'hABCD56);
    wide_mode = 0;
    lookup(32'h01123456); check_resp("R5 narrow top fault", 2'b11, 24'h000000);
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    req_valid = 1; req_addr = 32'h00123456;
    @(negedge clk);
    req_addr = 32'h001235AA;
    @(negedge clk);
    check_resp("R6 first", 2'b01, 24'hABCD56);
    req_addr = 32'h00203401;
    @(negedge clk);
    req_valid = 0;
    check_resp("R6 second", 2'b10, 24'h0101AA);
    @(negedge clk);
    check_resp("R6 third", 2'b00, 24'h5A5A01);
    @(negedge clk);
    check("R6 drains", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    resp_ready = 0;
    req_valid = 1; req_addr = 32'h00123456;
    @(negedge clk);
    req_addr = 32'h00203402;
    @(negedge clk);
    req_valid = 0;
    check_resp("R7 held A", 2'b01, 24'hABCD56);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_resp("R7 still A", 2'b01, 24'hABCD56);
      check("R7 ready low", {31'd0, req_ready}, 32'd0);
    end
    resp_ready = 1;
    @(negedge clk);
    check_resp("R7 then B", 2'b00, 24'h5A5A02);
    @(negedge clk);
    check("R7 empty", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic t_write_order();
    // L2 write presented at the accepting edge
    @(negedge clk);
    req_valid = 1; req_addr = 32'h00123456;
    cfg_we = 1; cfg_level = 1; cfg_table = 2'd2; cfg_index = 8'h34;
    cfg_data = {2'b10, 16'h2222};
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    @(negedge clk);
    check_resp("R8 same-cycle write unseen", 2'b01, 24'hABCD56);
    lookup(32'h00123456); check_resp("R8 later sees write", 2'b10, 24'h222256);
    // L1 invalidation one cycle after accept
    @(negedge clk);
    req_valid = 1; req_addr = 32'h00123456;
    @(negedge clk);
    req_valid = 0;
    cfg_we = 1; cfg_level = 0; cfg_index = 8'h12; cfg_data = 18'd0;
    @(negedge clk);
    cfg_we = 0;
    check_resp("R8 inflight keeps mapping", 2'b10, 24'h222256);
    lookup(32'h00123456); check_resp("R8 invalidation applies", 2'b11, 24'h000000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_basic();
    t_invalid();
    t_wide();
    t_pipeline();
    t_stall();
    t_write_order();
    finish_run();
  end
endmodule